// File: doc/BRIEF.md
# Timer-Shared Parallel Port

An 8-bit general-purpose parallel port whose pins can be taken over by the output-compare channels of a timer. A bus master writes a data latch and reads back the port state through one register at a fixed address. For each pin, the block decides whether it drives and what level it drives. A pad model outside the block turns these into pin levels and returns the sensed levels.

The pins have three kinds. Pins 2..0 are input-only and never drive. Pins 6..4 always drive. Pins 7 and 3 are bidirectional, and their direction comes from two direction bits held elsewhere. A timer output-compare channel that is enabled on a pin able to drive takes the pin over. The pin then drives, at the level the timer supplies, whatever its direction bit says and whatever the latch holds. The latch keeps taking writes while a pin is owned, and its value reaches the pin again once the timer lets go.

Top module: `tsp_port`

## Requirements
- R1: After reset the data latch is 0. With both direction inputs low and no output compare enabled, `pad_oe_o` is 8'h70, `pad_do_o` is 8'h00 and `rdata_o` is 0.
- R2: A write (`wr_i` high and `addr_i` equal to `PORT_ADDR`) loads `wdata_i` into the latch at the clock edge. A write to any other address leaves the latch unchanged. The latch value appears on `pad_do_o` for every pin that is not owned by the timer.
- R3: Pins 2..0 never drive. `pad_oe_o[2:0]` is 0 for any direction input and any output-compare enable, and `oc_en_i[2:0]` does not change `pad_do_o`.
- R4: Pins 6..4 always drive. Each pin's value is its latch bit, or its `oc_lvl_i` bit while its `oc_en_i` bit is set.
- R5: When no output compare is enabled on it, pin 7 drives exactly when `dir_i[1]` is 1, and pin 3 drives exactly when `dir_i[0]` is 1. A driving pin outputs its latch bit.
- R6: While `oc_en_i[7]` or `oc_en_i[3]` is set, that pin drives `oc_lvl_i` whatever its direction bit says. When the enable clears, the direction bit controls the pin again in the same cycle.
- R7: A write made while a pin is owned by the timer does not change that pin's driven value. The written bit appears on the pin as soon as the ownership ends.
- R8: A read at `PORT_ADDR` returns, one cycle later on `rdata_o`, each pin's `pad_do_o` bit if the pin is driving and its `pad_di_i` bit otherwise. The values are those present in the read cycle.
- R9: A read at any other address, or no read at all, gives `rdata_o` = 0 in the next cycle. Reads never change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Registered read data |
| dir_i | input | DIR_W | Direction bits for bidirectional pins, [1] for pin 7, [0] for pin 3 |
| oc_en_i | input | WIDTH | Per-pin output-compare enable from the timer |
| oc_lvl_i | input | WIDTH | Per-pin output-compare level from the timer |
| pad_di_i | input | WIDTH | Sensed pin levels from the pad model |
| pad_oe_o | output | WIDTH | Per-pin output enable to the pad model |
| pad_do_o | output | WIDTH | Per-pin driven value to the pad model |

## Verification
The assertions take the timer, direction and pad inputs to be synchronous to `clk_i` and free of X. They also take the pad readings to be sampled in the same cycle as a read, and the bus strobes to stay low during reset so that the first `$past` after reset sees an idle bus. The stimulus changes every input only at the falling clock edge and keeps the strobes low while reset is asserted. It sets `oc_en_i` on input-only pins as well, so that the rule that such enables are ignored is exercised, not assumed.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  typedef enum logic [1:0] {
    PIN_IN    = 2'd0,
    PIN_OUT   = 2'd1,
    PIN_BIDIR = 2'd2
  } pin_kind_e;

  // kind of pin at position pos, from the fixed-output and bidirectional masks
  function automatic pin_kind_e pin_kind(input logic [63:0] out_mask,
                                         input logic [63:0] bidir_mask,
                                         input int unsigned pos);
    if (bidir_mask[pos]) return PIN_BIDIR;
    if (out_mask[pos])   return PIN_OUT;
    return PIN_IN;
  endfunction

  // index of a bidirectional pin among the bidirectional pins, lowest first
  function automatic int unsigned bidir_rank(input logic [63:0] bidir_mask,
                                             input int unsigned pos);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k < pos && bidir_mask[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/tsp_bus_dec.sv
module tsp_bus_dec #(
  parameter int unsigned          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    PORT_ADDR = '0
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o
);

  logic hit;

  assign hit      = (addr_i == PORT_ADDR);
  assign rd_hit_o = rd_i & hit;
  assign wr_hit_o = wr_i & hit;

endmodule

// File: rtl/tsp_data_latch.sv
module tsp_data_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

endmodule

// File: rtl/tsp_pin_ctl.sv
module tsp_pin_ctl
  import tsp_pkg::*;
#(
  parameter int unsigned      WIDTH      = 8,
  parameter int unsigned      DIR_W      = 2,
  parameter logic [WIDTH-1:0] OUT_MASK   = 8'h70,
  parameter logic [WIDTH-1:0] BIDIR_MASK = 8'h88
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [DIR_W-1:0] dir_i,
  input  logic [WIDTH-1:0] oc_en_i,
  input  logic [WIDTH-1:0] oc_lvl_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] do_o,
  output logic [WIDTH-1:0] own_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam pin_kind_e KIND =
      pin_kind(64'(OUT_MASK), 64'(BIDIR_MASK), i);

    if (KIND == PIN_BIDIR) begin : g_bidir
      localparam int unsigned DIDX = bidir_rank(64'(BIDIR_MASK), i);
      // timer override wins over the stored direction bit
      assign own_o[i] = oc_en_i[i];
      assign oe_o[i]  = oc_en_i[i] | dir_i[DIDX];
      assign do_o[i]  = oc_en_i[i] ? oc_lvl_i[i] : latch_i[i];
    end else if (KIND == PIN_OUT) begin : g_out
      assign own_o[i] = oc_en_i[i];
      assign oe_o[i]  = 1'b1;
      assign do_o[i]  = oc_en_i[i] ? oc_lvl_i[i] : latch_i[i];
    end else begin : g_in
      logic unused_oc;
      assign unused_oc = oc_en_i[i] ^ oc_lvl_i[i];
      assign own_o[i]  = 1'b0;
      assign oe_o[i]   = 1'b0;
      assign do_o[i]   = latch_i[i];
    end
  end

endmodule

// File: rtl/tsp_readback.sv
module tsp_readback #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_hit_i,
  input  logic [WIDTH-1:0] oe_i,
  input  logic [WIDTH-1:0] do_i,
  input  logic [WIDTH-1:0] di_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] pin_view;

  // driving pins report the driver input, others the sensed level
  assign pin_view = (oe_i & do_i) | (~oe_i & di_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_hit_i ? pin_view : '0;
  end

endmodule

// File: rtl/tsp_port.sv
module tsp_port #(
  parameter int unsigned          WIDTH      = 8,
  parameter int unsigned          ADDR_W     = 4,
  parameter int unsigned          DIR_W      = 2,
  parameter logic [ADDR_W-1:0]    PORT_ADDR  = '0,
  parameter logic [WIDTH-1:0]     OUT_MASK   = 8'h70,
  parameter logic [WIDTH-1:0]     BIDIR_MASK = 8'h88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [DIR_W-1:0]  dir_i,
  input  logic [WIDTH-1:0]  oc_en_i,
  input  logic [WIDTH-1:0]  oc_lvl_i,
  input  logic [WIDTH-1:0]  pad_di_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_do_o
);

  logic             rd_hit;
  logic             wr_hit;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] own;

  tsp_bus_dec #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) i_dec (
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .rd_hit_o(rd_hit),
    .wr_hit_o(wr_hit)
  );

  tsp_data_latch #(.WIDTH(WIDTH)) i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_hit),
    .wdata_i(wdata_i),
    .q_o    (latch_q)
  );

  tsp_pin_ctl #(
    .WIDTH     (WIDTH),
    .DIR_W     (DIR_W),
    .OUT_MASK  (OUT_MASK),
    .BIDIR_MASK(BIDIR_MASK)
  ) i_pins (
    .latch_i (latch_q),
    .dir_i   (dir_i),
    .oc_en_i (oc_en_i),
    .oc_lvl_i(oc_lvl_i),
    .oe_o    (pad_oe_o),
    .do_o    (pad_do_o),
    .own_o   (own)
  );

  tsp_readback #(.WIDTH(WIDTH)) i_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hit_i(rd_hit),
    .oe_i    (pad_oe_o),
    .do_i    (pad_do_o),
    .di_i    (pad_di_i),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/tsp_port_chk.sv
module tsp_port_chk #(
  parameter int unsigned          WIDTH      = 8,
  parameter int unsigned          ADDR_W     = 4,
  parameter logic [ADDR_W-1:0]    PORT_ADDR  = '0,
  parameter logic [WIDTH-1:0]     OUT_MASK   = 8'h70,
  parameter logic [WIDTH-1:0]     BIDIR_MASK = 8'h88
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  oc_en_i,
  input logic [WIDTH-1:0]  oc_lvl_i,
  input logic [WIDTH-1:0]  pad_di_i,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  pad_do_o,
  input logic [WIDTH-1:0]  latch_q
);

  localparam logic [WIDTH-1:0] OC_MASK = OUT_MASK | BIDIR_MASK;
  localparam logic [WIDTH-1:0] IN_MASK = ~OC_MASK;

  logic wr_hit;
  logic rd_hit;
  assign wr_hit = wr_i && (addr_i == PORT_ADDR);
  assign rd_hit = rd_i && (addr_i == PORT_ADDR);

  AST_IN_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & IN_MASK) == '0);  // R3

  AST_FIXED_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & OUT_MASK) == OUT_MASK);  // R4

  AST_OC_FORCES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_en_i & OC_MASK & ~pad_oe_o) == '0);  // R6

  AST_OC_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_do_o ^ oc_lvl_i) & oc_en_i & OC_MASK) == '0);  // R7

  AST_WR_REACHES_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ((pad_do_o ^ $past(wdata_i)) & ~oc_en_i & OC_MASK) == '0);  // R2

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(latch_q));  // R9

  AST_RD_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> rdata_o == (($past(pad_oe_o) & $past(pad_do_o)) |
                           (~$past(pad_oe_o) & $past(pad_di_i))));  // R8

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> rdata_o == '0);  // R9

endmodule

bind tsp_port tsp_port_chk #(
  .WIDTH     (WIDTH),
  .ADDR_W    (ADDR_W),
  .PORT_ADDR (PORT_ADDR),
  .OUT_MASK  (OUT_MASK),
  .BIDIR_MASK(BIDIR_MASK)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .oc_en_i (oc_en_i),
  .oc_lvl_i(oc_lvl_i),
  .pad_di_i(pad_di_i),
  .pad_oe_o(pad_oe_o),
  .pad_do_o(pad_do_o),
  .latch_q (latch_q)
);

// File: tb/test_tsp_port.sv
module test_tsp_port;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] dir_i = '0;
  logic [7:0] oc_en_i = '0;
  logic [7:0] oc_lvl_i = '0;
  logic [7:0] pad_di_i = '0;
  logic [7:0] pad_oe_o;
  logic [7:0] pad_do_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] latch_m = '0;
  logic [7:0] exp_rd  = '0;
  bit         exp_hit = 1'b0;

  always #2ns clk_i = ~clk_i;

  tsp_port i_tsp_port (.*);

  function automatic logic [7:0] m_own(input logic [7:0] en);
    return en & 8'hF8;
  endfunction

  function automatic logic [7:0] m_oe(input logic [1:0] d, input logic [7:0] en);
    return 8'h70 | {d[1], 3'b000, d[0], 3'b000} | m_own(en);
  endfunction

  function automatic logic [7:0] m_do(input logic [7:0] l, input logic [7:0] en,
                                      input logic [7:0] lv);
    return (l & ~m_own(en)) | (lv & m_own(en));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge: checks last read, drives, checks pins, advances
  task automatic cyc(input bit rd, input bit wr, input logic [3:0] a,
                     input logic [7:0] wd, input logic [1:0] d,
                     input logic [7:0] en, input logic [7:0] lv, input logic [7:0] di);
    logic [7:0] eo, ed;
    check(exp_hit ? "R8" : "R9", rdata_o, exp_rd);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd;
    dir_i = d; oc_en_i = en; oc_lvl_i = lv; pad_di_i = di;
    #1ns;
    eo = m_oe(d, en);
    ed = m_do(latch_m, en, lv);
    check("R3", pad_oe_o & 8'h07, 8'h00);
    check("R3", pad_do_o & 8'h07, latch_m & 8'h07);
    check("R4", pad_oe_o & 8'h70, 8'h70);
    check((en & 8'h88) != 0 ? "R6" : "R5", pad_oe_o & 8'h88, eo & 8'h88);
    check("R2", pad_do_o & ~m_own(en), ed & ~m_own(en));
    check("R6", pad_do_o & m_own(en), ed & m_own(en));
    exp_hit = rd && (a == 4'h0);
    exp_rd  = exp_hit ? ((eo & ed) | (~eo & di)) : 8'h00;
    if (wr && a == 4'h0) latch_m = wd;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4ns);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1ns;
    check("R1", pad_oe_o, 8'h70);
    check("R1", pad_do_o, 8'h00);
    check("R1", rdata_o, 8'h00);
    @(negedge clk_i);

    // write to another address is ignored, then a hit lands
    cyc(0, 1, 4'h5, 8'hFF, 2'b00, 8'h00, 8'h00, 8'h00);
    cyc(0, 0, 4'h0, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00);
    check("R2", pad_do_o, 8'h00);
    cyc(0, 1, 4'h0, 8'hA5, 2'b11, 8'h00, 8'h00, 8'h00);
    cyc(1, 0, 4'h0, 8'h00, 2'b11, 8'h00, 8'h00, 8'h5A);
    check("R2", pad_do_o, 8'hA5);

    // pin 7 owned with direction low; write under ownership is held off
    cyc(0, 1, 4'h0, 8'hFF, 2'b00, 8'h80, 8'h00, 8'h00);
    cyc(1, 0, 4'h0, 8'h00, 2'b00, 8'h80, 8'h00, 8'hFF);
    check("R7", pad_do_o & 8'h80, 8'h00);
    check("R6", pad_oe_o & 8'h80, 8'h80);
    cyc(0, 0, 4'h0, 8'h00, 2'b10, 8'h00, 8'h00, 8'h00);
    check("R7", pad_do_o & 8'h80, 8'h80);

    // oc enables on input-only pins are ignored; reads leave latch alone
    cyc(1, 0, 4'h0, 8'h00, 2'b00, 8'h07, 8'h07, 8'h00);
    check("R3", pad_oe_o & 8'h07, 8'h00);
    cyc(1, 0, 4'h3, 8'h00, 2'b00, 8'h00, 8'h00, 8'hFF);
    cyc(1, 0, 4'h0, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00);
    check("R9", pad_do_o, 8'hFF);

    for (int n = 0; n < 2000; n++) begin
      logic [3:0] a;
      a = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      cyc(1'($urandom), 1'($urandom), a, 8'($urandom), 2'($urandom),
          8'($urandom) & 8'($urandom), 8'($urandom), 8'($urandom));
    end
    cyc(0, 0, 4'h0, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00);
    finish_run();
  end

endmodule